// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer at a time from a requester, described by a start byte address, a byte count and a direction. It cuts the transfer into pieces that never cross a cache-line boundary and hands them, one by one, to a downstream coherence controller over a valid/ready channel. It waits for a read response or a write acknowledgement before sending the next piece. When the last piece finishes, it answers the requester once.

A requester that arrives while a transfer is running is turned away and is not queued. The block remembers that a requester was turned away and raises a one-cycle retry pulse when it becomes free. The busy state is already clear in that cycle, so the retried request is taken at once. A drain input reports straight away when nothing is in flight. Otherwise it holds a draining level until the running transfer ends, then pulses drain-done.

Top module: `dma_line_splitter`

## Requirements
- R1: When `busy` is low (no transfer in flight), `req_valid` raises `req_accept` combinationally in the same cycle, and the transfer starts at that clock edge.
- R2: `req_valid` while a transfer is in flight raises `req_refuse` and not `req_accept`. The refused request is never issued downstream, and `mem_valid` is low in the cycle after the running transfer completes.
- R3: If a request was refused during a transfer, `retry_pulse` is high for exactly the one cycle after the final response. It stays low in every other case, and the record of the refusal is then cleared.
- R4: The first piece appears on `mem_valid` in the cycle after acceptance. Its `mem_addr` is the start address and its `mem_len` is min(total length, LINE_BYTES − start mod LINE_BYTES).
- R5: Every later piece appears in the cycle after the previous `mem_done` and starts at start + bytes done so far. That address is a multiple of LINE_BYTES, and `mem_len` is min(remaining bytes, LINE_BYTES).
- R6: `mem_line_addr` is `mem_addr` with its low log2(LINE_BYTES) bits cleared. `mem_store` is 1 for a write transfer (`req_write`=1) and 0 for a read.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_len` and `mem_store` hold their values.
- R8: While a piece is awaiting its response, `cap_offset` is the start offset within the line for the first piece and 0 for later pieces. `cap_len` equals that piece's length.
- R9: `resp_valid` pulses for one cycle, in the cycle after the final `mem_done`, only when the request had `req_need_resp`=1. `resp_write` then echoes the direction.
- R10: A request presented in the cycle of the completion response or retry pulse is accepted.
- R11: `drain_req` with no transfer in flight raises `drain_now` in the same cycle. With a transfer in flight it sets `draining` until completion, and `drain_done` pulses in the cycle after the final `mem_done`.
- R12: `mem_done` while no piece is awaiting a response (idle, or piece not yet taken by `mem_ready`) raises `proto_err` in that cycle and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester presents a transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count (non-zero) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_need_resp | input | 1 | Requester expects a completion response |
| req_accept | output | 1 | Transfer taken this cycle |
| req_refuse | output | 1 | Transfer refused, block busy |
| retry_pulse | output | 1 | A refused requester may try again |
| resp_valid | output | 1 | Completion response |
| resp_write | output | 1 | Direction of the completed transfer |
| mem_valid | output | 1 | Piece offered downstream |
| mem_ready | input | 1 | Downstream takes the piece |
| mem_addr | output | ADDR_W | Piece byte address |
| mem_line_addr | output | ADDR_W | Piece line address |
| mem_store | output | 1 | 1 = store, 0 = load |
| mem_len | output | log2(LINE_BYTES)+1 | Piece byte count |
| mem_done | input | 1 | Read data or write ack for the piece |
| cap_offset | output | log2(LINE_BYTES) | Offset to sample returned line from |
| cap_len | output | log2(LINE_BYTES)+1 | Bytes to sample from returned line |
| proto_err | output | 1 | Unexpected `mem_done` |
| drain_req | input | 1 | Drain request |
| drain_now | output | 1 | Already drained |
| draining | output | 1 | Drain pending on running transfer |
| drain_done | output | 1 | Pending drain completed |

## Verification
The bench builds the block with LINE_BYTES=16, LEN_W=8 and ADDR_W=16. The small line makes multi-piece transfers short. The largest length, 255 bytes from offset 15, then spans seventeen pieces, so first-piece trimming, runs of full lines and a short tail all show up within a few hundred cycles. The bench varies the stall cycles on `mem_ready`. It also places a refusal, a pending drain and a stray `mem_done` inside running transfers, and chains a new request into the completion cycle.

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              req_need_resp,
  output logic              req_accept,
  output logic              req_refuse,
  output logic              retry_pulse,
  output logic              resp_valid,
  output logic              resp_write,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_line_addr,
  output logic              mem_store,
  output logic [OFF_W:0]    mem_len,
  input  logic              mem_done,
  output logic [OFF_W-1:0]  cap_offset,
  output logic [OFF_W:0]    cap_len,
  output logic              proto_err,
  input  logic              drain_req,
  output logic              drain_now,
  output logic              draining,
  output logic              drain_done
);
  localparam logic [LEN_W:0] LINE_L = (LEN_W+1)'(LINE_BYTES);

  logic              busy, waiting, wr_q, nr_q, stalled_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q, issued_q, done_q;

  logic              fin, step, load;
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  src_rem, src_piece, inflight;
  logic [LEN_W:0]    src_room;

  assign req_accept = req_valid & ~busy;
  assign req_refuse = req_valid & busy;
  assign proto_err  = mem_done & ~waiting;
  assign drain_now  = drain_req & ~busy;
  assign fin        = waiting & mem_done & (issued_q == len_q);
  assign step       = waiting & mem_done & ~fin;
  assign load       = req_accept | step;

  assign src_addr  = busy ? start_q + ADDR_W'(issued_q) : req_addr;
  assign src_rem   = busy ? len_q - issued_q : req_len;
  assign src_room  = LINE_L - (LEN_W+1)'(src_addr[OFF_W-1:0]);
  assign src_piece = ({1'b0, src_rem} < src_room) ? src_rem : src_room[LEN_W-1:0];

  assign mem_line_addr = {mem_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_store     = wr_q;
  assign resp_write    = wr_q;
  assign inflight      = issued_q - done_q;
  assign cap_len       = inflight[OFF_W:0];
  assign cap_offset    = (done_q == '0) ? start_q[OFF_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; waiting <= 1'b0; mem_valid <= 1'b0;
      wr_q <= 1'b0; nr_q <= 1'b0; stalled_q <= 1'b0;
      start_q <= '0; len_q <= '0; issued_q <= '0; done_q <= '0;
      mem_addr <= '0; mem_len <= '0;
      resp_valid <= 1'b0; retry_pulse <= 1'b0;
      draining <= 1'b0; drain_done <= 1'b0;
    end else begin
      resp_valid  <= fin & nr_q;
      retry_pulse <= fin & (stalled_q | req_refuse);
      drain_done  <= fin & (draining | drain_req);
      if (fin) begin
        busy <= 1'b0; stalled_q <= 1'b0; draining <= 1'b0;
      end else begin
        stalled_q <= stalled_q | req_refuse;
        draining  <= draining | (drain_req & busy);
      end
      if (load) begin
        mem_valid <= 1'b1;
        mem_addr  <= src_addr;
        mem_len   <= src_piece[OFF_W:0];
      end else if (mem_valid && mem_ready) begin
        mem_valid <= 1'b0;
      end
      if (mem_valid && mem_ready) waiting <= 1'b1;
      else if (mem_done)          waiting <= 1'b0;
      if (req_accept) begin
        busy <= 1'b1; start_q <= req_addr; len_q <= req_len;
        wr_q <= req_write; nr_q <= req_need_resp;
        issued_q <= src_piece; done_q <= '0;
      end else if (step) begin
        done_q   <= issued_q;
        issued_q <= issued_q + src_piece;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_store));
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && done_q != '0 |-> mem_addr[OFF_W-1:0] == '0);
  p_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (32'(mem_addr[OFF_W-1:0]) + 32'(mem_len)) <= LINE_BYTES);
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && waiting));
  p_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy && $past(waiting && mem_done));
  p_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> !busy && !stalled_q);
  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !busy && !draining);
endmodule

// File: tb/dma_line_splitter_tb.sv
module dma_line_splitter_tb;
  localparam int AW = 16, LW = 8, LB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_need_resp = 0, mem_ready = 0, mem_done = 0, drain_req = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_accept, req_refuse, retry_pulse, resp_valid, resp_write, mem_valid, mem_store;
  logic proto_err, drain_now, draining, drain_done;
  logic [AW-1:0] mem_addr, mem_line_addr;
  logic [4:0] mem_len, cap_len;
  logic [3:0] cap_offset;

  always #10 clk = ~clk;

  dma_line_splitter #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB)) u_dut (
    .clk, .rst_n, .req_valid, .req_addr, .req_len, .req_write, .req_need_resp,
    .req_accept, .req_refuse, .retry_pulse, .resp_valid, .resp_write,
    .mem_valid, .mem_ready, .mem_addr, .mem_line_addr, .mem_store, .mem_len,
    .mem_done, .cap_offset, .cap_len, .proto_err, .drain_req, .drain_now,
    .draining, .drain_done);

  int nchk = 0, nfail = 0, cyc = 0;
  bit started = 0, pend_resp = 0, pend_retry = 0, pend_dd = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit e_resp, e_retry, e_dd;
    e_resp = pend_resp; e_retry = pend_retry; e_dd = pend_dd;
    pend_resp = 0; pend_retry = 0; pend_dd = 0;
    cyc++;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
    #5;
    if (started) begin
      chk("R9 resp_valid", resp_valid, e_resp);
      chk("R3 retry_pulse", retry_pulse, e_retry);
      chk("R11 drain_done", drain_done, e_dd);
    end
  end

  task automatic xfer(input int addr, input int len, input bit wr, input bit nr,
                      input int refuse_at, input int drain_at, input bit perr);
    int pa[$], pl[$];
    int a = addr, rem = len, p;
    bit refused = 0, drn = 0;
    while (rem > 0) begin
      p = LB - (a % LB);
      if (rem < p) p = rem;
      pa.push_back(a); pl.push_back(p);
      a += p; rem -= p;
    end
    req_valid = 1; req_addr = AW'(addr); req_len = LW'(len);
    req_write = wr; req_need_resp = nr;
    #1 chk("R1/R10 req_accept", req_accept, 1);
    @(negedge clk) req_valid = 0;
    for (int i = 0; i < pa.size(); i++) begin
      chk(i == 0 ? "R4 mem_valid" : "R5 mem_valid", mem_valid, 1);
      for (int s = 0; s < i % 3; s++) begin
        if (perr && s == 0) begin
          mem_done = 1;
          #1 chk("R12 proto_err pending", proto_err, 1);
          mem_done = 0;
        end
        @(negedge clk);
        chk("R7 hold valid", mem_valid, 1);
        chk("R7 hold addr", mem_addr, pa[i]);
      end
      chk(i == 0 ? "R4 addr" : "R5 addr", mem_addr, pa[i]);
      chk(i == 0 ? "R4 len" : "R5 len", mem_len, pl[i]);
      chk("R6 line addr", mem_line_addr, pa[i] & ~(LB - 1));
      chk("R6 store", mem_store, wr);
      mem_ready = 1;
      @(negedge clk) mem_ready = 0;
      chk("R2 single piece", mem_valid, 0);
      if (i == refuse_at) begin
        req_valid = 1; req_addr = 16'h7770;
        #1 chk("R2 refuse", req_refuse, 1);
        chk("R2 no accept", req_accept, 0);
        refused = 1;
        @(negedge clk) req_valid = 0;
      end
      if (i == drain_at) begin
        drain_req = 1;
        #1 chk("R11 drain_now busy", drain_now, 0);
        drn = 1;
        @(negedge clk) drain_req = 0;
        chk("R11 draining", draining, 1);
      end
      chk("R8 cap_offset", cap_offset, i == 0 ? addr % LB : 0);
      chk("R8 cap_len", cap_len, pl[i]);
      mem_done = 1;
      if (i == pa.size() - 1) begin
        pend_resp = nr; pend_retry = refused; pend_dd = drn;
      end
      @(negedge clk) mem_done = 0;
    end
    chk("R2 nothing queued", mem_valid, 0);
    if (nr) chk("R9 resp_write", resp_write, wr);
    chk("R11 draining cleared", draining, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    started = 1;
    @(negedge clk);
    chk("R1 reset mem_valid", mem_valid, 0);
    chk("R1 reset draining", draining, 0);
    mem_done = 1;
    #1 chk("R12 proto_err idle", proto_err, 1);
    mem_done = 0;
    @(negedge clk);
    chk("R12 no effect", mem_valid, 0);
    drain_req = 1;
    #1 chk("R11 drain_now idle", drain_now, 1);
    @(negedge clk) drain_req = 0;
    chk("R11 no draining idle", draining, 0);

    xfer(16'h0005, 3, 0, 1, -1, -1, 0);
    @(negedge clk);
    xfer(16'h000C, 20, 1, 1, 0, -1, 0);
    xfer(16'h0003, 50, 0, 1, -1, 2, 1);
    @(negedge clk);
    xfer(16'h0040, 32, 1, 0, 1, 1, 0);
    xfer(16'h01F1, 255, 0, 1, 5, -1, 1);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule